// File: doc/BRIEF.md
# Power-Management Event Status Register

This block holds the latched power-management events of a chip. Hardware events set individual status flags; software removes a flag only by writing a 1 to its position. A companion enable register selects which flags may act. The block drives three requests. A wake request is raised while the system sleeps. In the working state, an interrupt request goes to either the SCI line or the SMI# line, depending on a global routing bit.

Each implemented flag belongs to one of three reset domains. Core-domain bits are lost on a hard reset. Resume-domain bits survive a hard reset but not a resume-well reset. The override flag sits in the battery-backed domain and survives both. This lets software see, after a power loss or a forced shutdown, why the system went down.

Flag positions, fixed because software decodes them: bit 0 timer event, bit 5 global event, bit 8 button event, bit 10 RTC alarm, bit 11 button override, bit 15 wake. The enable register implements bits 0, 5, 8 and 10 (mask 0x0521). The status register implements mask 0x8D21.

Top module: `pm_evt_status`

## Requirements
- R1: After all three resets, the status register reads 0x0000, the enable register reads 0x0000, and wake_req, sci_req and smi_req are 0.
- R2: An event input that is high at a clock edge sets its flag at that edge: evt_tmr sets bit 0, evt_glb bit 5, evt_btn bit 8, evt_rtc bit 10, and either evt_ovr_hold or evt_ovr_msg sets bit 11. A flag stays set until it is cleared.
- R3: A status write clears each implemented flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R4: When a flag's event and a write-1 clear of that flag land on the same edge, the flag ends up set.
- R5: Unimplemented positions read 0 in both registers and ignore writes. A write to the enable register loads only bits 0, 5, 8 and 10, so writing 0xFFFF reads back 0x0521.
- R6: A hard reset alone clears status bits 0 and 5 and enable bits 0 and 5. It leaves status bits 8, 10, 11 and 15 and enable bits 8 and 10 unchanged.
- R7: A resume-well reset clears every status and enable bit except status bit 11.
- R8: wake_req is 1 exactly when sleeping is 1 and (bit 10 and its enable are both 1, or bit 8 and its enable are both 1). Bits 0 and 5 never raise wake_req.
- R9: A cycle with wake_req high sets status bit 15 at the next edge. Bit 15 is never set while sleeping is 0.
- R10: With sleeping at 0, a pending flag among bits 0, 5, 8 and 10 whose enable is set raises sci_req when sci_en is 1. When sci_en is 0 it raises smi_req instead, and bit 5 is excluded from smi_req. While sleeping, both interrupt requests are 0.
- R11: The battery-well reset clears every bit of both registers, bit 11 included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Synchronous active-low hard reset (core domain) |
| resume_rst_n | input | 1 | Synchronous active-low resume-well reset |
| rtc_rst_n | input | 1 | Synchronous active-low battery-well reset |
| sts_wr_en | input | 1 | Status write strobe (write-1-to-clear) |
| sts_wr_data | input | 16 | Status write data |
| en_wr_en | input | 1 | Enable register write strobe |
| en_wr_data | input | 16 | Enable register write data |
| evt_tmr | input | 1 | Timer event (bit 0) |
| evt_glb | input | 1 | Global event (bit 5) |
| evt_btn | input | 1 | Button event (bit 8) |
| evt_rtc | input | 1 | RTC alarm (bit 10) |
| evt_ovr_hold | input | 1 | Button held past override time (bit 11) |
| evt_ovr_msg | input | 1 | Override request from management bus (bit 11) |
| sleeping | input | 1 | System is in a sleep state entered via sleep enable |
| sci_en | input | 1 | 1 routes interrupts to SCI, 0 to SMI# |
| sts_rd | output | 16 | Status register contents |
| en_rd | output | 16 | Enable register contents |
| wake_req | output | 1 | Wake request |
| sci_req | output | 1 | SCI interrupt request |
| smi_req | output | 1 | SMI# interrupt request (active high here) |

## Verification
The hardest state to reach is one where the three reset domains hold different histories. This needs a wake flag recorded during sleep, resume-domain and core-domain flags pending, and the override flag set, all at once before any reset fires. The bench builds that state step by step. It enables the RTC alarm, enters sleep and raises the alarm so that the wake flag latches. It then adds timer, global and override events. Next it applies the hard, resume-well and battery-well resets one at a time, in that order, and reads back after each which flags survived.

// File: rtl/pm_evt_pkg.sv
// Package: shared constants for the power-management event status block.
// Assumes a 16-bit register; bit positions are fixed because software decodes them.
package pm_evt_pkg;
    localparam int REG_W = 16;

    // Reset domain of a storage bit.
    typedef enum logic [1:0] {
        DOM_CORE   = 2'd0,   // lost on hard, resume or battery reset
        DOM_RESUME = 2'd1,   // lost on resume or battery reset
        DOM_RTC    = 2'd2    // lost on battery reset only
    } dom_e;

    localparam int B_TMR = 0;
    localparam int B_GLB = 5;
    localparam int B_BTN = 8;
    localparam int B_RTC = 10;
    localparam int B_OVR = 11;
    localparam int B_WAK = 15;

    localparam logic [REG_W-1:0] STS_MASK  = 16'h8D21;
    localparam logic [REG_W-1:0] EN_MASK   = 16'h0521;
    localparam logic [REG_W-1:0] WAKE_SRC  = 16'h0500;
    localparam logic [REG_W-1:0] SCI_SRC   = 16'h0521;
    localparam logic [REG_W-1:0] SMI_SRC   = 16'h0501;

    // Domain of bit position b: low byte core, override bit battery, rest resume.
    function automatic dom_e bit_domain(input int b);
        if (b == B_OVR)
            return DOM_RTC;
        else if (b < 8)
            return DOM_CORE;
        else
            return DOM_RESUME;
    endfunction
endpackage

// File: rtl/pm_reg_bit.sv
// Module: one storage bit of the status or enable register.
// W1C=1: hardware set, software write-1 clear, set wins a collision.
// W1C=0: plain read/write bit loaded on wr.
// Assumes the domain resets arrive already combined (outer resets folded in).
module pm_reg_bit #(
    parameter pm_evt_pkg::dom_e DOMAIN = pm_evt_pkg::DOM_CORE,
    parameter bit W1C = 1'b1
) (
    input  logic clk,
    input  logic rst_core_n,
    input  logic rst_resume_n,
    input  logic rst_rtc_n,
    input  logic set,
    input  logic wr,
    input  logic wdata,
    output logic q
);
    logic dom_rst_n;
    logic unused_set;

    // Pick the reset that owns this bit.
    always_comb begin
        case (DOMAIN)
            pm_evt_pkg::DOM_CORE:   dom_rst_n = rst_core_n;
            pm_evt_pkg::DOM_RESUME: dom_rst_n = rst_resume_n;
            default:                dom_rst_n = rst_rtc_n;
        endcase
    end

    assign unused_set = set;

    // Bit storage with domain reset.
    always_ff @(posedge clk) begin
        if (!dom_rst_n)
            q <= 1'b0;
        else if (W1C)
            q <= set | (q & ~(wr & wdata));
        else if (wr)
            q <= wdata;
    end
endmodule

// File: rtl/pm_evt_route.sv
// Module: routes enabled flags to wake, SCI or SMI# requests.
// Purely combinational; inputs are register outputs, so requests are glitch-free per cycle.
module pm_evt_route #(
    parameter int W = pm_evt_pkg::REG_W
) (
    input  logic [W-1:0] sts,
    input  logic [W-1:0] en,
    input  logic         sleeping,
    input  logic         sci_en,
    output logic         wake_req,
    output logic         wake_set,
    output logic         sci_req,
    output logic         smi_req
);
    import pm_evt_pkg::*;

    logic [W-1:0] armed;
    logic         wake_hit;
    logic         sci_hit;
    logic         smi_hit;

    // Flags that are both pending and enabled, filtered per destination.
    always_comb begin
        armed    = sts & en;
        wake_hit = |(armed & WAKE_SRC[W-1:0]);
        sci_hit  = |(armed & SCI_SRC[W-1:0]);
        smi_hit  = |(armed & SMI_SRC[W-1:0]);
    end

    // Wake only in sleep; interrupts only in the working state.
    always_comb begin
        wake_req = sleeping & wake_hit;
        wake_set = wake_req;
        sci_req  = ~sleeping & sci_en & sci_hit;
        smi_req  = ~sleeping & ~sci_en & smi_hit;
    end
endmodule

// File: rtl/pm_evt_status.sv
// Module: power-management event status and enable registers with request routing.
// Assumes resets are synchronous, active low, and that outer wells reset inner ones.
module pm_evt_status (
    input  logic        clk,
    input  logic        hard_rst_n,
    input  logic        resume_rst_n,
    input  logic        rtc_rst_n,
    input  logic        sts_wr_en,
    input  logic [15:0] sts_wr_data,
    input  logic        en_wr_en,
    input  logic [15:0] en_wr_data,
    input  logic        evt_tmr,
    input  logic        evt_glb,
    input  logic        evt_btn,
    input  logic        evt_rtc,
    input  logic        evt_ovr_hold,
    input  logic        evt_ovr_msg,
    input  logic        sleeping,
    input  logic        sci_en,
    output logic [15:0] sts_rd,
    output logic [15:0] en_rd,
    output logic        wake_req,
    output logic        sci_req,
    output logic        smi_req
);
    import pm_evt_pkg::*;

    localparam int W = REG_W;

    logic         rst_core_n;
    logic         rst_resume_n;
    logic         rst_rtc_n;
    logic [W-1:0] hw_set;
    logic         wake_set;
    logic         unused_bits;

    // Fold outer-well resets into inner domains.
    always_comb begin
        rst_rtc_n    = rtc_rst_n;
        rst_resume_n = resume_rst_n & rtc_rst_n;
        rst_core_n   = hard_rst_n & resume_rst_n & rtc_rst_n;
    end

    // Map event inputs onto status positions.
    always_comb begin
        hw_set        = '0;
        hw_set[B_TMR] = evt_tmr;
        hw_set[B_GLB] = evt_glb;
        hw_set[B_BTN] = evt_btn;
        hw_set[B_RTC] = evt_rtc;
        hw_set[B_OVR] = evt_ovr_hold | evt_ovr_msg;
        hw_set[B_WAK] = wake_set;
    end

    assign unused_bits = ^{sts_wr_data & ~STS_MASK, en_wr_data & ~EN_MASK, hw_set & ~STS_MASK};

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (STS_MASK[i]) begin : g_sts
            pm_reg_bit #(.DOMAIN(bit_domain(i)), .W1C(1'b1)) u_sts (
                .clk          (clk),
                .rst_core_n   (rst_core_n),
                .rst_resume_n (rst_resume_n),
                .rst_rtc_n    (rst_rtc_n),
                .set          (hw_set[i]),
                .wr           (sts_wr_en),
                .wdata        (sts_wr_data[i]),
                .q            (sts_rd[i])
            );
        end else begin : g_sts_rsvd
            assign sts_rd[i] = 1'b0;
        end

        if (EN_MASK[i]) begin : g_en
            pm_reg_bit #(.DOMAIN(bit_domain(i)), .W1C(1'b0)) u_en (
                .clk          (clk),
                .rst_core_n   (rst_core_n),
                .rst_resume_n (rst_resume_n),
                .rst_rtc_n    (rst_rtc_n),
                .set          (1'b0),
                .wr           (en_wr_en),
                .wdata        (en_wr_data[i]),
                .q            (en_rd[i])
            );
        end else begin : g_en_rsvd
            assign en_rd[i] = 1'b0;
        end
    end

    pm_evt_route #(.W(W)) u_route (
        .sts      (sts_rd),
        .en       (en_rd),
        .sleeping (sleeping),
        .sci_en   (sci_en),
        .wake_req (wake_req),
        .wake_set (wake_set),
        .sci_req  (sci_req),
        .smi_req  (smi_req)
    );
endmodule

// File: rtl/pm_evt_status_chk.sv
// Module: assertion checker bound to pm_evt_status; observes ports only.
module pm_evt_status_chk (
    input logic        clk,
    input logic        hard_rst_n,
    input logic        resume_rst_n,
    input logic        rtc_rst_n,
    input logic        sts_wr_en,
    input logic [15:0] sts_wr_data,
    input logic        evt_rtc,
    input logic        evt_ovr_hold,
    input logic        evt_ovr_msg,
    input logic        sleeping,
    input logic [15:0] sts_rd,
    input logic [15:0] en_rd,
    input logic        wake_req
);
    logic all_n;
    assign all_n = hard_rst_n & resume_rst_n & rtc_rst_n;

    // R4: an RTC alarm always leaves bit 10 set, even against a clear.
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!all_n)
        evt_rtc |=> sts_rd[10]);

    // R3: write-1 clears bit 10 when no alarm competes.
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!all_n)
        (sts_wr_en && sts_wr_data[10] && !evt_rtc) |=> !sts_rd[10]);

    // R3: writing 0 to the override bit keeps it.
    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!all_n)
        (sts_wr_en && !sts_wr_data[11] && sts_rd[11]) |=> sts_rd[11]);

    // R8: no wake request in the working state.
    a_r8_awake_no_wake: assert property (@(posedge clk) disable iff (!all_n)
        !sleeping |-> !wake_req);

    // R8: without the bit 8/10 enables, no wake request.
    a_r8_needs_enable: assert property (@(posedge clk) disable iff (!all_n)
        ((en_rd & 16'h0500) == 16'h0000) |-> !wake_req);

    // R9: a wake request records the wake flag on the next edge.
    a_r9_wak_follows: assert property (@(posedge clk) disable iff (!all_n)
        wake_req |=> sts_rd[15]);

    // R6: a hard reset alone leaves the override flag untouched.
    a_r6_ovr_survives: assert property (@(posedge clk) disable iff (!rtc_rst_n || !resume_rst_n)
        (!hard_rst_n && !sts_wr_en && !evt_ovr_hold && !evt_ovr_msg) |=> $stable(sts_rd[11]));
endmodule

bind pm_evt_status pm_evt_status_chk u_chk (
    .clk          (clk),
    .hard_rst_n   (hard_rst_n),
    .resume_rst_n (resume_rst_n),
    .rtc_rst_n    (rtc_rst_n),
    .sts_wr_en    (sts_wr_en),
    .sts_wr_data  (sts_wr_data),
    .evt_rtc      (evt_rtc),
    .evt_ovr_hold (evt_ovr_hold),
    .evt_ovr_msg  (evt_ovr_msg),
    .sleeping     (sleeping),
    .sts_rd       (sts_rd),
    .en_rd        (en_rd),
    .wake_req     (wake_req)
);

// File: tb/pm_evt_status_bench.sv
// Bench: vector table for set/clear behaviour, then directed routing and reset-domain tests.
module pm_evt_status_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;
    localparam int WATCHDOG = 5000;

    // Row: {tmr,glb,btn,rtc,ovr_hold,ovr_msg}, wr_en, wr_data, expected status after the edge.
    localparam logic [38:0] VEC [NV] = '{
        {6'b100000, 1'b0, 16'h0000, 16'h0001},
        {6'b000100, 1'b0, 16'h0000, 16'h0401},
        {6'b000000, 1'b1, 16'h0001, 16'h0400},
        {6'b000000, 1'b1, 16'h0000, 16'h0400},
        {6'b000010, 1'b0, 16'h0000, 16'h0C00},
        {6'b010000, 1'b1, 16'hFFFF, 16'h0020},
        {6'b001001, 1'b0, 16'h0000, 16'h0920},
        {6'b000000, 1'b1, 16'h7000, 16'h0920},
        {6'b000000, 1'b1, 16'h0920, 16'h0000},
        {6'b111111, 1'b1, 16'h0401, 16'h0D21},
        {6'b000000, 1'b1, 16'hFFFF, 16'h0000}
    };
    localparam int VTAG [NV] = '{2, 2, 3, 3, 2, 4, 2, 5, 3, 4, 3};

    logic        clk = 1'b0;
    logic        hard_rst_n, resume_rst_n, rtc_rst_n;
    logic        sts_wr_en, en_wr_en;
    logic [15:0] sts_wr_data, en_wr_data;
    logic        evt_tmr, evt_glb, evt_btn, evt_rtc, evt_ovr_hold, evt_ovr_msg;
    logic        sleeping, sci_en;
    logic [15:0] sts_rd, en_rd;
    logic        wake_req, sci_req, smi_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    pm_evt_status u_pm_evt_status (
        .clk(clk), .hard_rst_n(hard_rst_n), .resume_rst_n(resume_rst_n), .rtc_rst_n(rtc_rst_n),
        .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .en_wr_en(en_wr_en), .en_wr_data(en_wr_data),
        .evt_tmr(evt_tmr), .evt_glb(evt_glb), .evt_btn(evt_btn), .evt_rtc(evt_rtc),
        .evt_ovr_hold(evt_ovr_hold), .evt_ovr_msg(evt_ovr_msg), .sleeping(sleeping), .sci_en(sci_en),
        .sts_rd(sts_rd), .en_rd(en_rd), .wake_req(wake_req), .sci_req(sci_req), .smi_req(smi_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock edge, then return at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_evts(input logic [5:0] e);
        {evt_tmr, evt_glb, evt_btn, evt_rtc, evt_ovr_hold, evt_ovr_msg} = e;
    endtask

    task automatic pulse_evts(input logic [5:0] e);
        set_evts(e);
        step();
        set_evts(6'b0);
    endtask

    task automatic wr_sts(input logic [15:0] d);
        sts_wr_en = 1'b1; sts_wr_data = d;
        step();
        sts_wr_en = 1'b0; sts_wr_data = '0;
    endtask

    task automatic wr_en(input logic [15:0] d);
        en_wr_en = 1'b1; en_wr_data = d;
        step();
        en_wr_en = 1'b0; en_wr_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        hard_rst_n = 0; resume_rst_n = 0; rtc_rst_n = 0;
        sts_wr_en = 0; sts_wr_data = '0; en_wr_en = 0; en_wr_data = '0;
        set_evts(6'b0); sleeping = 0; sci_en = 1;
        step(); step();
        hard_rst_n = 1; resume_rst_n = 1; rtc_rst_n = 1;
        step();

        // R1: reset state
        chk("R1 status", sts_rd, 16'h0000);
        chk("R1 enable", en_rd, 16'h0000);
        chk("R1 requests", {13'b0, wake_req, sci_req, smi_req}, 16'h0000);

        // Table walk: R2, R3, R4, R5 on the status register
        for (int i = 0; i < NV; i++) begin
            set_evts(VEC[i][38:33]);
            sts_wr_en = VEC[i][32];
            sts_wr_data = VEC[i][31:16];
            step();
            set_evts(6'b0); sts_wr_en = 0; sts_wr_data = '0;
            chk($sformatf("R%0d row %0d", VTAG[i], i), sts_rd, VEC[i][15:0]);
        end

        // R5: enable register keeps only implemented bits
        wr_en(16'hFFFF);
        chk("R5 enable mask", en_rd, 16'h0521);

        // R10: routing in the working state
        sleeping = 0; sci_en = 1;
        pulse_evts(6'b010000);
        chk("R10 sci from bit5", {14'b0, sci_req, smi_req}, 16'h0002);
        sci_en = 0; #1;
        chk("R10 bit5 no smi", {14'b0, sci_req, smi_req}, 16'h0000);
        pulse_evts(6'b100000);
        chk("R10 smi from bit0", {14'b0, sci_req, smi_req}, 16'h0001);
        sleeping = 1; #1;
        chk("R10 quiet in sleep", {14'b0, sci_req, smi_req}, 16'h0000);
        chk("R8 bits0/5 no wake", {15'b0, wake_req}, 16'h0000);
        // R9: no wake flag while awake even with an enabled alarm
        sleeping = 0;
        pulse_evts(6'b000100);
        step();
        chk("R9 no wak awake", sts_rd, 16'h0421);
        wr_sts(16'hFFFF);

        // R8 / R9: wake path in sleep
        wr_en(16'h0400);
        sleeping = 1;
        pulse_evts(6'b001000);
        chk("R8 btn not enabled", {15'b0, wake_req}, 16'h0000);
        pulse_evts(6'b000100);
        chk("R8 rtc status", sts_rd, 16'h0500);
        chk("R8 rtc wake", {15'b0, wake_req}, 16'h0001);
        step();
        chk("R9 wak set", sts_rd, 16'h8500);

        // R6 / R7 / R11: reset domains
        wr_en(16'h0521);
        pulse_evts(6'b110010);
        sleeping = 0;
        chk("R6 pre status", sts_rd, 16'h8D21);
        hard_rst_n = 0; step(); hard_rst_n = 1;
        chk("R6 hard status", sts_rd, 16'h8D00);
        chk("R6 hard enable", en_rd, 16'h0500);
        resume_rst_n = 0; step(); resume_rst_n = 1;
        chk("R7 resume status", sts_rd, 16'h0800);
        chk("R7 resume enable", en_rd, 16'h0000);
        rtc_rst_n = 0; step(); rtc_rst_n = 1;
        chk("R11 rtc status", sts_rd, 16'h0000);

        finish_run();
    end
endmodule